// File: doc/BRIEF.md
# Extended-Page Control Opcode Executor

This block executes the control group of an 8-bit processor's extended (second-byte) opcode page. These are the opcodes that move data between the accumulator and the interrupt-vector (I) or refresh (R) registers, return from an interrupt, negate the accumulator, or select the interrupt mode. The surrounding core presents an opcode byte together with its current accumulator, I, R, flag byte, both interrupt-enable flip-flops and interrupt mode. The block then hands back the updated values. When a return is needed, it raises a one-cycle request for an external stack unit, which does the actual pop. It also recognises opcodes outside its group and reports them with a one-cycle illegal-opcode pulse instead of changing anything.

A small controller sequences the work through three states. `ST_IDLE` waits for `op_valid`. On the accepting edge it captures all inputs and moves to `ST_EXEC`. `ST_EXEC` decodes the captured opcode and registers every result, then always moves to `ST_DONE`. `ST_DONE` presents the results with `res_valid` high for exactly one cycle and always returns to `ST_IDLE`. `busy` is high in `ST_EXEC` and `ST_DONE`. Inputs that arrive while the block is busy are not looked at.

Top module: `xpage_ctrl_unit`

## Requirements
- R1: Opcode 0x47 writes the captured accumulator into I, and opcode 0x4F writes it into R. The accumulator, flags, IFF1 and interrupt mode come back unchanged.
- R2: Opcode 0x57 loads the accumulator from I, and 0x5F loads it from R after the R increment of R7. In the flag byte (S bit 7, Z bit 6, H bit 4, P/V bit 2, N bit 1, C bit 0), S is set to result bit 7, Z is set when the result is zero, H and N are cleared, P/V takes IFF2, and C is kept.
- R3: The opcodes 0x45, 0x55, 0x5D, 0x65, 0x6D, 0x75 and 0x7D all behave the same way: IFF1 is given the value of IFF2, and `ret_req` pulses together with `res_valid`.
- R4: Opcode 0x4D pulses `ret_req` and returns IFF1 unchanged.
- R5: Each of 0x44, 0x4C, 0x54, 0x5C, 0x64, 0x6C, 0x74 and 0x7C sets the accumulator to 0 minus the accumulator. S and Z follow the result. H is set when the low nibble of the operand is nonzero. P/V is set when the operand was 0x80. N is set. C is set when the operand was nonzero. Flag positions are as in R2.
- R6: Interrupt mode becomes 0 for 0x46 and 0x66, 1 for 0x56 and 0x76, and 2 for 0x5E and 0x7E. The mode is carried as an unsigned code on `res_im`.
- R7: Every recognised opcode other than 0x4F returns R with its low 7 bits incremented modulo 128 and bit 7 unchanged.
- R8: Any other opcode pulses `illegal_op` for the one `res_valid` cycle, does not pulse `ret_req`, and returns every state value (including R) equal to its captured input.
- R9: An opcode is accepted on a rising edge where `op_valid` is high and `busy` is low. `busy` is high for the next two cycles. `res_valid` is high only in the second of them. Inputs that change while `busy` is high do not affect the result.
- R10: Flag bits 5 and 3 are returned unchanged for every opcode.
- R11: While `rst_n` is low and after it is released, `busy`, `res_valid`, `ret_req` and `illegal_op` are low until an opcode is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode and state inputs are presented |
| op_code | input | 8 | Second byte of the extended opcode |
| cur_a | input | DW | Current accumulator |
| cur_i | input | DW | Current interrupt-vector register |
| cur_r | input | DW | Current refresh register |
| cur_iff1 | input | 1 | Current interrupt enable flip-flop 1 |
| cur_iff2 | input | 1 | Current interrupt enable flip-flop 2 |
| cur_f | input | 8 | Current flag byte |
| cur_im | input | IMW | Current interrupt mode |
| busy | output | 1 | Executor is in ST_EXEC or ST_DONE |
| res_valid | output | 1 | Results are valid (ST_DONE) |
| res_a | output | DW | Updated accumulator |
| res_i | output | DW | Updated interrupt-vector register |
| res_r | output | DW | Updated refresh register |
| res_iff1 | output | 1 | Updated interrupt enable flip-flop 1 |
| res_f | output | 8 | Updated flag byte |
| res_im | output | IMW | Updated interrupt mode |
| ret_req | output | 1 | One-cycle return request to the stack unit |
| illegal_op | output | 1 | One-cycle pulse for an unrecognised opcode |

## Verification
The assertions assume that the values on the `cur_*` inputs and `op_code` matter only on the accepting edge. The checker therefore keeps its own copy of them, taken on that edge, and relates each result to that copy rather than to the live inputs. The stimulus drives every input on the falling edge and drops `op_valid` after one accepting edge. It also deliberately changes the opcode and the operands while `busy` is high, so the captured-copy assumption is actually exercised and not merely avoided. The interrupt mode presented is always one of the three defined codes, as the mode outputs assume.

// File: rtl/xpage_pkg.sv
package xpage_pkg;

    localparam int OPC_W = 8;
    localparam int FLG_W = 8;

    // flag byte bit positions
    localparam int FB_S = 7;
    localparam int FB_Z = 6;
    localparam int FB_H = 4;
    localparam int FB_P = 2;
    localparam int FB_N = 1;
    localparam int FB_C = 0;

    typedef enum logic [3:0] {
        K_LD_I_A,
        K_LD_R_A,
        K_LD_A_I,
        K_LD_A_R,
        K_RETN,
        K_RETI,
        K_NEG,
        K_IM0,
        K_IM1,
        K_IM2,
        K_BAD
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXEC,
        ST_DONE
    } ctrl_state_e;

endpackage

// File: rtl/xpage_decode.sv
module xpage_decode
    import xpage_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output op_kind_e         kind
);

    always_comb begin
        kind = K_BAD;
        if (opc[7:6] == 2'b01) begin
            unique case (opc[2:0])
                3'd4: kind = K_NEG;
                3'd5: kind = (opc[5:3] == 3'd1) ? K_RETI : K_RETN;
                3'd6: begin
                    unique case (opc[4:3])
                        2'b00:   kind = K_IM0;
                        2'b10:   kind = K_IM1;
                        2'b11:   kind = K_IM2;
                        default: kind = K_BAD;
                    endcase
                end
                3'd7: begin
                    if (!opc[5]) begin
                        unique case (opc[4:3])
                            2'b00:   kind = K_LD_I_A;
                            2'b01:   kind = K_LD_R_A;
                            2'b10:   kind = K_LD_A_I;
                            default: kind = K_LD_A_R;
                        endcase
                    end
                end
                default: kind = K_BAD;
            endcase
        end
    end

endmodule

// File: rtl/xpage_neg_alu.sv
module xpage_neg_alu #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] opnd,
    output logic [DW-1:0] res,
    output logic          f_s,
    output logic          f_z,
    output logic          f_h,
    output logic          f_p,
    output logic          f_c
);

    localparam logic [DW-1:0] MIN_NEG = {1'b1, {(DW-1){1'b0}}};

    always_comb begin
        res = {DW{1'b0}} - opnd;
        f_s = res[DW-1];
        f_z = ~|res;
        f_h = |opnd[3:0];
        f_p = (opnd == MIN_NEG);
        f_c = |opnd;
    end

endmodule

// File: rtl/xpage_refresh.sv
module xpage_refresh #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] r_cur,
    output logic [DW-1:0] r_next
);

    localparam logic [DW-2:0] ONE_LOW = {{(DW-2){1'b0}}, 1'b1};

    assign r_next = {r_cur[DW-1], r_cur[DW-2:0] + ONE_LOW};

endmodule

// File: rtl/xpage_ctrl_unit.sv
module xpage_ctrl_unit
    import xpage_pkg::*;
#(
    parameter int DW  = 8,
    parameter int IMW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [OPC_W-1:0] op_code,
    input  logic [DW-1:0]    cur_a,
    input  logic [DW-1:0]    cur_i,
    input  logic [DW-1:0]    cur_r,
    input  logic             cur_iff1,
    input  logic             cur_iff2,
    input  logic [FLG_W-1:0] cur_f,
    input  logic [IMW-1:0]   cur_im,
    output logic             busy,
    output logic             res_valid,
    output logic [DW-1:0]    res_a,
    output logic [DW-1:0]    res_i,
    output logic [DW-1:0]    res_r,
    output logic             res_iff1,
    output logic [FLG_W-1:0] res_f,
    output logic [IMW-1:0]   res_im,
    output logic             ret_req,
    output logic             illegal_op
);

    localparam logic [IMW-1:0] IM_CODE0 = IMW'(0);
    localparam logic [IMW-1:0] IM_CODE1 = IMW'(1);
    localparam logic [IMW-1:0] IM_CODE2 = IMW'(2);

    ctrl_state_e state_q, state_d;

    // captured operands
    logic [OPC_W-1:0] l_op;
    logic [DW-1:0]    l_a, l_i, l_r;
    logic             l_iff1, l_iff2;
    logic [FLG_W-1:0] l_f;
    logic [IMW-1:0]   l_im;

    // next results
    logic [DW-1:0]    nx_a, nx_i, nx_r;
    logic             nx_iff1;
    logic [FLG_W-1:0] nx_f;
    logic [IMW-1:0]   nx_im;
    logic             nx_ret, nx_ill;

    // registered results
    logic             q_ret, q_ill;

    op_kind_e         kind;
    logic [DW-1:0]    r_inc;
    logic [DW-1:0]    neg_res;
    logic             neg_s, neg_z, neg_h, neg_p, neg_c;
    logic [DW-1:0]    ld_val;
    logic             accept;

    xpage_decode u_dec (
        .opc  (l_op),
        .kind (kind)
    );

    xpage_refresh #(.DW(DW)) u_ref (
        .r_cur  (l_r),
        .r_next (r_inc)
    );

    xpage_neg_alu #(.DW(DW)) u_neg (
        .opnd (l_a),
        .res  (neg_res),
        .f_s  (neg_s),
        .f_z  (neg_z),
        .f_h  (neg_h),
        .f_p  (neg_p),
        .f_c  (neg_c)
    );

    assign accept = (state_q == ST_IDLE) && op_valid;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (op_valid) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // operand capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_op   <= '0;
            l_a    <= '0;
            l_i    <= '0;
            l_r    <= '0;
            l_iff1 <= 1'b0;
            l_iff2 <= 1'b0;
            l_f    <= '0;
            l_im   <= '0;
        end else if (accept) begin
            l_op   <= op_code;
            l_a    <= cur_a;
            l_i    <= cur_i;
            l_r    <= cur_r;
            l_iff1 <= cur_iff1;
            l_iff2 <= cur_iff2;
            l_f    <= cur_f;
            l_im   <= cur_im;
        end
    end

    assign ld_val = (kind == K_LD_A_I) ? l_i : r_inc;

    // execution
    always_comb begin
        nx_a    = l_a;
        nx_i    = l_i;
        nx_r    = r_inc;
        nx_iff1 = l_iff1;
        nx_f    = l_f;
        nx_im   = l_im;
        nx_ret  = 1'b0;
        nx_ill  = 1'b0;
        unique case (kind)
            K_LD_I_A: nx_i = l_a;
            K_LD_R_A: nx_r = l_a;
            K_LD_A_I, K_LD_A_R: begin
                nx_a       = ld_val;
                nx_f[FB_S] = ld_val[DW-1];
                nx_f[FB_Z] = ~|ld_val;
                nx_f[FB_H] = 1'b0;
                nx_f[FB_N] = 1'b0;
                nx_f[FB_P] = l_iff2;
            end
            K_RETN: begin
                nx_iff1 = l_iff2;
                nx_ret  = 1'b1;
            end
            K_RETI: nx_ret = 1'b1;
            K_NEG: begin
                nx_a       = neg_res;
                nx_f[FB_S] = neg_s;
                nx_f[FB_Z] = neg_z;
                nx_f[FB_H] = neg_h;
                nx_f[FB_P] = neg_p;
                nx_f[FB_N] = 1'b1;
                nx_f[FB_C] = neg_c;
            end
            K_IM0: nx_im = IM_CODE0;
            K_IM1: nx_im = IM_CODE1;
            K_IM2: nx_im = IM_CODE2;
            default: begin
                nx_r   = l_r;
                nx_ill = 1'b1;
            end
        endcase
    end

    // result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_a    <= '0;
            res_i    <= '0;
            res_r    <= '0;
            res_iff1 <= 1'b0;
            res_f    <= '0;
            res_im   <= '0;
            q_ret    <= 1'b0;
            q_ill    <= 1'b0;
        end else if (state_q == ST_EXEC) begin
            res_a    <= nx_a;
            res_i    <= nx_i;
            res_r    <= nx_r;
            res_iff1 <= nx_iff1;
            res_f    <= nx_f;
            res_im   <= nx_im;
            q_ret    <= nx_ret;
            q_ill    <= nx_ill;
        end
    end

    // state-decoded outputs
    always_comb begin
        busy       = 1'b0;
        res_valid  = 1'b0;
        ret_req    = 1'b0;
        illegal_op = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_EXEC: busy = 1'b1;
            ST_DONE: begin
                busy       = 1'b1;
                res_valid  = 1'b1;
                ret_req    = q_ret;
                illegal_op = q_ill;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/xpage_ctrl_unit_chk.sv
module xpage_ctrl_unit_chk #(
    parameter int DW  = 8,
    parameter int IMW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [7:0]    op_code,
    input logic [DW-1:0] cur_a,
    input logic [DW-1:0] cur_i,
    input logic [DW-1:0] cur_r,
    input logic          cur_iff1,
    input logic          cur_iff2,
    input logic [7:0]    cur_f,
    input logic [IMW-1:0] cur_im,
    input logic          busy,
    input logic          res_valid,
    input logic [DW-1:0] res_a,
    input logic [DW-1:0] res_i,
    input logic [DW-1:0] res_r,
    input logic          res_iff1,
    input logic [7:0]    res_f,
    input logic [IMW-1:0] res_im,
    input logic          ret_req,
    input logic          illegal_op
);

    localparam logic [DW-2:0] ONE_LOW = {{(DW-2){1'b0}}, 1'b1};

    logic [7:0]     c_op;
    logic [DW-1:0]  c_a, c_i, c_r;
    logic           c_iff1, c_iff2;
    logic [7:0]     c_f;
    logic [IMW-1:0] c_im;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_op <= '0; c_a <= '0; c_i <= '0; c_r <= '0;
            c_iff1 <= 1'b0; c_iff2 <= 1'b0; c_f <= '0; c_im <= '0;
        end else if (op_valid && !busy) begin
            c_op <= op_code; c_a <= cur_a; c_i <= cur_i; c_r <= cur_r;
            c_iff1 <= cur_iff1; c_iff2 <= cur_iff2; c_f <= cur_f; c_im <= cur_im;
        end
    end

    AST_RETN_COPIES_IFF2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && c_op == 8'h45) |-> (ret_req && res_iff1 == c_iff2)); // R3
    AST_RETI_KEEPS_IFF1: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && c_op == 8'h4D) |-> (ret_req && res_iff1 == c_iff1)); // R4
    AST_REFRESH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !illegal_op && c_op != 8'h4F) |->
        (res_r[DW-1] == c_r[DW-1] && res_r[DW-2:0] == c_r[DW-2:0] + ONE_LOW)); // R7
    AST_ILLEGAL_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> (res_valid && !ret_req && res_a == c_a && res_i == c_i &&
                        res_r == c_r && res_f == c_f && res_im == c_im &&
                        res_iff1 == c_iff1)); // R8
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy) |=> (busy && !res_valid)); // R9
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R9
    AST_RET_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req || illegal_op) |-> res_valid); // R9
    AST_FLAG_GAP_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_f[5] == c_f[5] && res_f[3] == c_f[3])); // R10

endmodule

bind xpage_ctrl_unit xpage_ctrl_unit_chk #(.DW(DW), .IMW(IMW)) chk_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .cur_a(cur_a), .cur_i(cur_i), .cur_r(cur_r), .cur_iff1(cur_iff1),
    .cur_iff2(cur_iff2), .cur_f(cur_f), .cur_im(cur_im), .busy(busy),
    .res_valid(res_valid), .res_a(res_a), .res_i(res_i), .res_r(res_r),
    .res_iff1(res_iff1), .res_f(res_f), .res_im(res_im), .ret_req(ret_req),
    .illegal_op(illegal_op)
);

// File: tb/xpage_ctrl_unit_tb_top.sv
module xpage_ctrl_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_valid;
    logic [7:0] op_code;
    logic [7:0] cur_a, cur_i, cur_r, cur_f;
    logic       cur_iff1, cur_iff2;
    logic [1:0] cur_im;
    logic       busy, res_valid, res_iff1, ret_req, illegal_op;
    logic [7:0] res_a, res_i, res_r, res_f;
    logic [1:0] res_im;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    xpage_ctrl_unit #(.DW(8), .IMW(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .cur_a(cur_a), .cur_i(cur_i), .cur_r(cur_r), .cur_iff1(cur_iff1),
        .cur_iff2(cur_iff2), .cur_f(cur_f), .cur_im(cur_im), .busy(busy),
        .res_valid(res_valid), .res_a(res_a), .res_i(res_i), .res_r(res_r),
        .res_iff1(res_iff1), .res_f(res_f), .res_im(res_im), .ret_req(ret_req),
        .illegal_op(illegal_op)
    );

    // op, a, i, r, iff2, f, im | exp a, i, r, f, iff1, im, ret, ill  (iff1 in = ~iff2)
    localparam int NV = 22;
    localparam logic [79:0] VEC [NV] = '{
        {8'h47, 8'h3C, 8'h00, 8'h05, 1'b0, 8'hFF, 2'd0, 8'h3C, 8'h3C, 8'h06, 8'hFF, 1'b1, 2'd0, 1'b0, 1'b0},
        {8'h4F, 8'hA5, 8'h11, 8'h22, 1'b1, 8'h00, 2'd1, 8'hA5, 8'h11, 8'hA5, 8'h00, 1'b0, 2'd1, 1'b0, 1'b0},
        {8'h57, 8'h00, 8'h80, 8'h7F, 1'b1, 8'h00, 2'd2, 8'h80, 8'h80, 8'h00, 8'h84, 1'b0, 2'd2, 1'b0, 1'b0},
        {8'h57, 8'h12, 8'h00, 8'hFF, 1'b0, 8'hFF, 2'd0, 8'h00, 8'h00, 8'h80, 8'h69, 1'b1, 2'd0, 1'b0, 1'b0},
        {8'h5F, 8'h00, 8'h00, 8'h40, 1'b0, 8'h12, 2'd1, 8'h41, 8'h00, 8'h41, 8'h00, 1'b1, 2'd1, 1'b0, 1'b0},
        {8'h45, 8'h77, 8'h01, 8'h10, 1'b1, 8'hAA, 2'd2, 8'h77, 8'h01, 8'h11, 8'hAA, 1'b1, 2'd2, 1'b1, 1'b0},
        {8'h7D, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 2'd0, 8'h00, 8'h00, 8'h01, 8'h00, 1'b0, 2'd0, 1'b1, 1'b0},
        {8'h4D, 8'h01, 8'h02, 8'h03, 1'b1, 8'h55, 2'd1, 8'h01, 8'h02, 8'h04, 8'h55, 1'b0, 2'd1, 1'b1, 1'b0},
        {8'h44, 8'h01, 8'h00, 8'h00, 1'b0, 8'h00, 2'd0, 8'hFF, 8'h00, 8'h01, 8'h93, 1'b1, 2'd0, 1'b0, 1'b0},
        {8'h7C, 8'h80, 8'h00, 8'h00, 1'b0, 8'h00, 2'd0, 8'h80, 8'h00, 8'h01, 8'h87, 1'b1, 2'd0, 1'b0, 1'b0},
        {8'h5C, 8'h00, 8'h00, 8'h00, 1'b0, 8'hFF, 2'd0, 8'h00, 8'h00, 8'h01, 8'h6A, 1'b1, 2'd0, 1'b0, 1'b0},
        {8'h6C, 8'h10, 8'h00, 8'h00, 1'b0, 8'h00, 2'd0, 8'hF0, 8'h00, 8'h01, 8'h83, 1'b1, 2'd0, 1'b0, 1'b0},
        {8'h66, 8'h00, 8'h00, 8'h7F, 1'b0, 8'h00, 2'd2, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 2'd0, 1'b0, 1'b0},
        {8'h56, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 2'd0, 8'h00, 8'h00, 8'h01, 8'h00, 1'b1, 2'd1, 1'b0, 1'b0},
        {8'h7E, 8'h55, 8'h66, 8'h80, 1'b1, 8'h3C, 2'd1, 8'h55, 8'h66, 8'h81, 8'h3C, 1'b0, 2'd2, 1'b0, 1'b0},
        {8'h5E, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 2'd0, 8'h00, 8'h00, 8'h01, 8'h00, 1'b1, 2'd2, 1'b0, 1'b0},
        {8'h46, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 2'd1, 8'h00, 8'h00, 8'h01, 8'h00, 1'b1, 2'd0, 1'b0, 1'b0},
        {8'h76, 8'h00, 8'h00, 8'hFF, 1'b0, 8'h00, 2'd2, 8'h00, 8'h00, 8'h80, 8'h00, 1'b1, 2'd1, 1'b0, 1'b0},
        {8'h4E, 8'h11, 8'h22, 8'h33, 1'b1, 8'h44, 2'd1, 8'h11, 8'h22, 8'h33, 8'h44, 1'b0, 2'd1, 1'b0, 1'b1},
        {8'h00, 8'h00, 8'h00, 8'hFF, 1'b0, 8'hFF, 2'd2, 8'h00, 8'h00, 8'hFF, 8'hFF, 1'b1, 2'd2, 1'b0, 1'b1},
        {8'h67, 8'h9A, 8'h00, 8'h7F, 1'b0, 8'h00, 2'd0, 8'h9A, 8'h00, 8'h7F, 8'h00, 1'b1, 2'd0, 1'b0, 1'b1},
        {8'h6E, 8'h00, 8'h00, 8'h01, 1'b1, 8'h00, 2'd2, 8'h00, 8'h00, 8'h01, 8'h00, 1'b0, 2'd2, 1'b0, 1'b1}
    };

    function automatic string tag_for(input logic [7:0] op);
        case (op)
            8'h47, 8'h4F: return "R1";
            8'h57, 8'h5F: return "R2";
            8'h4D: return "R4";
            8'h45, 8'h55, 8'h5D, 8'h65, 8'h6D, 8'h75, 8'h7D: return "R3";
            8'h44, 8'h4C, 8'h54, 8'h5C, 8'h64, 8'h6C, 8'h74, 8'h7C: return "R5";
            8'h46, 8'h66, 8'h56, 8'h76, 8'h5E, 8'h7E: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] op, a, i, r, input logic ff2,
                         input logic [7:0] f, input logic [1:0] im);
        op_code  = op;
        cur_a    = a;
        cur_i    = i;
        cur_r    = r;
        cur_iff2 = ff2;
        cur_iff1 = ~ff2;
        cur_f    = f;
        cur_im   = im;
        op_valid = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 2'd0);
        op_valid = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset holds everything idle even with op_valid high
        check(!busy && !res_valid && !ret_req && !illegal_op, "R11", "idle in reset",
              {busy, res_valid, ret_req, illegal_op}, 0);
        op_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !res_valid && !ret_req && !illegal_op, "R11", "idle after reset",
              {busy, res_valid, ret_req, illegal_op}, 0);

        for (int k = 0; k < NV; k++) begin
            logic [79:0] v;
            string t;
            v = VEC[k];
            t = tag_for(v[79:72]);
            drive(v[79:72], v[71:64], v[63:56], v[55:48], v[47], v[46:39], v[38:37]);
            @(posedge clk);
            @(negedge clk);
            op_valid = 1'b0;
            check(busy && !res_valid, "R9", "exec cycle", {busy, res_valid}, 2);
            @(posedge clk);
            @(negedge clk);
            check(res_valid, "R9", "valid in done", res_valid, 1);
            check(res_a == v[36:29], t, "res_a", res_a, v[36:29]);
            check(res_i == v[28:21], t, "res_i", res_i, v[28:21]);
            check(res_r == v[20:13], (t == "R8") ? "R8" : "R7", "res_r", res_r, v[20:13]);
            check(res_f == v[12:5], t, "res_f (R10 gap bits)", res_f, v[12:5]);
            check(res_iff1 == v[4], t, "res_iff1", res_iff1, v[4]);
            check(res_im == v[3:2], t, "res_im", res_im, v[3:2]);
            check(ret_req == v[1], t, "ret_req", ret_req, v[1]);
            check(illegal_op == v[0], t, "illegal_op", illegal_op, v[0]);
            @(posedge clk);
            @(negedge clk);
            check(!busy && !res_valid && !ret_req && !illegal_op, "R9", "back to idle",
                  {busy, res_valid, ret_req, illegal_op}, 0);
        end

        // R9: inputs changed while busy must not affect the result
        drive(8'h57, 8'h00, 8'h5A, 8'h00, 1'b1, 8'h00, 2'd0);
        @(posedge clk);
        @(negedge clk);
        drive(8'h4E, 8'hEE, 8'h00, 8'h70, 1'b0, 8'hFF, 2'd1);
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        check(res_valid && !illegal_op, "R9", "busy-time op ignored", illegal_op, 0);
        check(res_a == 8'h5A, "R9", "result from captured I", res_a, 8'h5A);
        check(res_f == 8'h04, "R9", "flags from captured IFF2", res_f, 8'h04);
        check(res_r == 8'h01, "R9", "R from captured value", res_r, 8'h01);
        @(posedge clk);
        @(negedge clk);
        check(!res_valid, "R9", "no second result", res_valid, 0);

        // R11: reset in the middle of an operation returns to idle
        drive(8'h45, 8'h00, 8'h00, 8'h00, 1'b1, 8'h00, 2'd0);
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(!busy && !res_valid && !ret_req, "R11", "reset aborts op",
              {busy, res_valid, ret_req}, 0);
        @(posedge clk);
        @(negedge clk);
        check(!res_valid && !ret_req, "R11", "no late return", {res_valid, ret_req}, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule